// File: doc/BRIEF.md
# Prescaled Overflow Timer with Period Postscaler

This block turns the system clock into long, exactly known time intervals. Each input clock counts as one oscillator period. A fixed divide-by-four stage makes an instruction tick from it. The tick passes through a prescaler whose ratio is a power of two. The prescaled steps then drive an up-counter, which runs either 8 or 16 bits wide. When the counter reaches its top value it reloads a programmed start value, and that event is an overflow.

Every overflow does two things: it sets a sticky flag, which stays set until a clear pulse removes it, and it toggles a square-wave output. A postscaler counts overflows. After a programmed number of them it fires a one-cycle period strobe. The full period in clock cycles is 4 · N1 · N2 · N3:

- N1 is the prescale ratio.
- N2 is the counter modulus, the top value plus one, minus the reload value.
- N3 is the postscale count.

For example, an overflow every 4 ms with N3 = 125 gives a 0.5 s strobe, and N3 = 330 gives 1.32 s.

Software or a parent block sets up the configuration inputs while the enable input is low. Raising the enable starts a fresh, complete interval.

Top module: `ovf_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, flag_o, wave_o and period_o are all 0.
- R2: After en_i rises, the first overflow comes exactly 4·N1·N2 clock edges later. Each later overflow follows the one before it by the same amount. N1 = 2^psc_sel_i for psc_sel_i from 0 to 8, and any psc_sel_i value above 8 gives N1 = 256.
- R3: With wide_i = 1 the counter is 16 bits wide and N2 = 65536 − reload_i. With wide_i = 0 only reload_i[7:0] is used, and N2 = 256 − reload_i[7:0].
- R4: An overflow sets flag_o from the next cycle on. flag_o then stays at 1 until flag_clr_i is sampled high, and after that clear it reads 0.
- R5: If flag_clr_i is high on the same edge as an overflow, the overflow wins and flag_o stays at 1.
- R6: wave_o toggles once on each overflow, so its period is twice the overflow interval.
- R7: period_o is high for exactly one cycle on every N3-th overflow, in the same cycle that the flag for that overflow first shows. N3 = post_n_i, and a value of 0 counts as 1.
- R8: While en_i is low there are no overflows, and flag_o, wave_o and period_o keep their values. Raising en_i again restarts the divider, the prescaler, the counter (from the reload value) and the postscaler, so the next overflow takes a full R2 interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the chain in its start state |
| wide_i | input | 1 | Counter width: 1 = 16-bit, 0 = 8-bit |
| psc_sel_i | input | 4 | Prescale exponent; ratio is 2^value, capped at 256 |
| reload_i | input | 16 | Counter start value loaded on enable and on each overflow |
| post_n_i | input | 10 | Overflows per period strobe (0 treated as 1) |
| flag_clr_i | input | 1 | Clears the overflow flag |
| flag_o | output | 1 | Sticky overflow flag |
| wave_o | output | 1 | Square wave, toggles on each overflow |
| period_o | output | 1 | One-cycle strobe at the end of each postscaled period |

## Verification
The assertions assume that wide_i, psc_sel_i, reload_i and post_n_i only change while en_i is low. If one of them changes during a run, an interval can be cut short or stretched, which is outside the contract. The bench follows this rule: it applies every configuration with the enable low and holds it for two edges before raising the enable. It raises flag_clr_i only on chosen edges, which include one edge that coincides with an overflow. That way the set-over-clear priority is exercised, while the flag still keeps a known value on every other edge.

// File: rtl/ovf_timer_pkg.sv
`timescale 1ns/1ps
package ovf_timer_pkg;
   // Counter width selection as seen by the counting stage
   typedef enum logic {
      CW_NARROW = 1'b0,
      CW_FULL   = 1'b1
   } cnt_width_e;

   // Smallest number of bits that can hold the value v
   function automatic int bits_for(input int v);
      int b;
      b = 1;
      while ((1 << b) <= v) b++;
      return b;
   endfunction
endpackage

// File: rtl/ovf_timer_tickdiv.sv
`timescale 1ns/1ps
module ovf_timer_tickdiv #(
   parameter int DIV_LOG2 = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic tick_o
);
   if (DIV_LOG2 < 1) begin : g_bad_div
      $error("DIV_LOG2 must be at least 1");
   end

   logic [DIV_LOG2-1:0] phase_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     phase_q <= '0;
      else if (!run_i) phase_q <= '0;
      else             phase_q <= phase_q + 1'b1;
   end

   assign tick_o = run_i && (phase_q == '1);

   // R2: the tick can never be high on two edges in a row
   a_r2_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
endmodule

// File: rtl/ovf_timer_presc.sv
`timescale 1ns/1ps
module ovf_timer_presc #(
   parameter int PSC_LOG2_MAX = 8,
   parameter int PSEL_W       = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic [PSEL_W-1:0] sel_i,
   output logic              step_o
);
   if ((1 << PSEL_W) <= PSC_LOG2_MAX) begin : g_bad_sel
      $error("PSEL_W too narrow for PSC_LOG2_MAX");
   end

   if (PSC_LOG2_MAX == 0) begin : g_bypass
      logic unused_p;
      assign unused_p = clk_i ^ rst_ni ^ run_i ^ (^sel_i);
      assign step_o   = tick_i;
   end else begin : g_div
      localparam logic [PSEL_W-1:0] SEL_MAX = PSEL_W'(PSC_LOG2_MAX);

      logic [PSC_LOG2_MAX-1:0] pcnt_q;
      logic [PSC_LOG2_MAX-1:0] mask;
      logic [PSEL_W-1:0]       sel_c;

      // The exponent saturates at the largest ratio the counter can make
      always_comb begin
         sel_c = (sel_i > SEL_MAX) ? SEL_MAX : sel_i;
         for (int i = 0; i < PSC_LOG2_MAX; i++)
            mask[i] = (PSEL_W'(i) < sel_c);
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     pcnt_q <= '0;
         else if (!run_i) pcnt_q <= '0;
         else if (tick_i) pcnt_q <= pcnt_q + 1'b1;
      end

      assign step_o = tick_i && ((pcnt_q & mask) == mask);

      // R2: while disabled, no prescaled step may leave this stage
      a_r2_step_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !run_i |-> !step_o);
   end
endmodule

// File: rtl/ovf_timer_count.sv
`timescale 1ns/1ps
module ovf_timer_count
   import ovf_timer_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int NARROW_W   = 8,
   parameter bit HAS_NARROW = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             step_i,
   input  logic             wide_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] FULL_TOP   = '1;
   localparam logic [CNT_W-1:0] NARROW_TOP = CNT_W'((1 << NARROW_W) - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] top_val;
   logic [CNT_W-1:0] load_val;

   if (HAS_NARROW) begin : g_two_widths
      cnt_width_e mode;
      assign mode     = cnt_width_e'(wide_i);
      assign top_val  = (mode == CW_FULL) ? FULL_TOP : NARROW_TOP;
      assign load_val = (mode == CW_FULL) ? reload_i
                      : {{(CNT_W-NARROW_W){1'b0}}, reload_i[NARROW_W-1:0]};
   end else begin : g_one_width
      logic unused_w;
      assign unused_w = wide_i;
      assign top_val  = FULL_TOP;
      assign load_val = reload_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (!run_i) cnt_q <= load_val;
      else if (step_i) cnt_q <= (cnt_q == top_val) ? load_val : cnt_q + 1'b1;
   end

   assign ovf_o = step_i && (cnt_q == top_val);

   // R3: in narrow mode with a steady setup the upper bits stay clear
   a_r3_narrow_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (HAS_NARROW && !wide_i && $past(!wide_i) && !$past(run_i))
      |-> (cnt_q[CNT_W-1:NARROW_W] == '0));
endmodule

// File: rtl/ovf_timer_post.sv
`timescale 1ns/1ps
module ovf_timer_post #(
   parameter int POST_W = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic              ovf_i,
   input  logic [POST_W-1:0] n_i,
   output logic              strobe_o
);
   logic [POST_W-1:0] ocnt_q;
   logic [POST_W-1:0] n_last;
   logic              strobe_q;

   // Index of the overflow that closes a period; a count of 0 acts as 1
   assign n_last = (n_i == '0) ? '0 : n_i - 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ocnt_q   <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= 1'b0;
         if (!run_i) begin
            ocnt_q <= '0;
         end else if (ovf_i) begin
            if (ocnt_q >= n_last) begin
               ocnt_q   <= '0;
               strobe_q <= 1'b1;
            end else begin
               ocnt_q <= ocnt_q + 1'b1;
            end
         end
      end
   end

   assign strobe_o = strobe_q;

   // R7: a strobe is always caused by an overflow one edge earlier
   a_r7_strobe_from_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_o |-> $past(ovf_i));
   // R7: the strobe lasts a single cycle
   a_r7_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_o |=> !strobe_o);
endmodule

// File: rtl/ovf_timer.sv
`timescale 1ns/1ps
module ovf_timer #(
   parameter int CNT_W        = 16,
   parameter int NARROW_W     = 8,
   parameter bit HAS_NARROW   = 1'b1,
   parameter int PSC_LOG2_MAX = 8,
   parameter int PSEL_W       = ovf_timer_pkg::bits_for(PSC_LOG2_MAX),
   parameter int POST_W       = 10,
   parameter int DIV_LOG2     = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              wide_i,
   input  logic [PSEL_W-1:0] psc_sel_i,
   input  logic [CNT_W-1:0]  reload_i,
   input  logic [POST_W-1:0] post_n_i,
   input  logic              flag_clr_i,
   output logic              flag_o,
   output logic              wave_o,
   output logic              period_o
);
   if (HAS_NARROW && (NARROW_W >= CNT_W)) begin : g_bad_width
      $error("NARROW_W must be smaller than CNT_W");
   end
   if (POST_W < 1) begin : g_bad_post
      $error("POST_W must be at least 1");
   end

   logic tick;
   logic step;
   logic ovf;
   logic flag_q;
   logic wave_q;

   ovf_timer_tickdiv #(.DIV_LOG2(DIV_LOG2)) i_tickdiv (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (en_i),
      .tick_o(tick)
   );

   ovf_timer_presc #(.PSC_LOG2_MAX(PSC_LOG2_MAX), .PSEL_W(PSEL_W)) i_presc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (en_i),
      .tick_i(tick),
      .sel_i (psc_sel_i),
      .step_o(step)
   );

   ovf_timer_count #(.CNT_W(CNT_W), .NARROW_W(NARROW_W), .HAS_NARROW(HAS_NARROW)) i_count (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (en_i),
      .step_i  (step),
      .wide_i  (wide_i),
      .reload_i(reload_i),
      .ovf_o   (ovf)
   );

   ovf_timer_post #(.POST_W(POST_W)) i_post (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (en_i),
      .ovf_i   (ovf),
      .n_i     (post_n_i),
      .strobe_o(period_o)
   );

   // Sticky flag: setting has priority over clearing
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q <= 1'b0;
      else if (ovf)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  wave_q <= 1'b0;
      else if (ovf) wave_q <= ~wave_q;
   end

   assign flag_o = flag_q;
   assign wave_o = wave_q;

   // R4: an overflow is visible on the flag one edge later
   a_r4_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf |=> flag_o);
   // R5: a clear without an overflow empties the flag
   a_r5_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_clr_i && !ovf) |=> !flag_o);
   // R6: each overflow flips the wave
   a_r6_wave_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf |=> (wave_o != $past(wave_o)));
   // R8: nothing moves while the enable is low
   a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> ($stable(wave_o) && !period_o));
endmodule

// File: tb/test_ovf_timer.sv
`timescale 1ns/1ps
module test_ovf_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       wide = 1'b1;
   logic [3:0] psel = '0;
   logic [15:0] reload = '0;
   logic [9:0] post_n = '0;
   logic       clr = 1'b0;
   logic       flag, wave, period;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   ovf_timer i_ovf_timer (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wide_i(wide),
      .psc_sel_i(psel), .reload_i(reload), .post_n_i(post_n),
      .flag_clr_i(clr), .flag_o(flag), .wave_o(wave), .period_o(period)
   );

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic setup(input logic w, input int ps, input int rl, input int n3);
      @(negedge clk);
      en = 1'b0; wide = w; psel = 4'(ps); reload = 16'(rl); post_n = 10'(n3); clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      @(negedge clk);
   endtask

   // R2 R3 R6 R7: run 2*N3 overflows and measure edges from enable
   task automatic run_case(input string req, input logic w, input int ps, input int rl, input int n3);
      int n1, n2, n3e, p, first_flag, toggles, last_tog, strobes, first_stb;
      logic prev_w;
      n1  = 1 << ((ps > 8) ? 8 : ps);
      n2  = w ? (65536 - rl) : (256 - (rl & 255));
      n3e = (n3 == 0) ? 1 : n3;
      p   = 4 * n1 * n2;
      setup(w, ps, rl, n3);
      first_flag = -1; toggles = 0; last_tog = -1; strobes = 0; first_stb = -1;
      prev_w = wave;
      en = 1'b1;
      for (int k = 1; k <= 2 * n3e * p; k++) begin
         @(posedge clk); #1;
         if (flag && first_flag < 0) first_flag = k;
         if (wave != prev_w) begin toggles++; last_tog = k; end
         prev_w = wave;
         if (period) begin strobes++; if (first_stb < 0) first_stb = k; end
      end
      @(negedge clk); en = 1'b0;
      check(req, "first overflow edge", first_flag, p);
      check("R6", "wave toggles", toggles, 2 * n3e);
      check("R6", "last toggle edge", last_tog, 2 * n3e * p);
      check("R7", "strobe cycles", strobes, 2);
      check("R7", "first strobe edge", first_stb, n3e * p);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", "flag in reset", flag, 0);
      check("R1", "wave in reset", wave, 0);
      check("R1", "period in reset", period, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", "flag after reset", flag, 0);
      check("R1", "period after reset", period, 0);

      // R2: prescaler sweep including saturated selects
      for (int s = 0; s <= 10; s++) run_case("R2", 1'b1, s, 16'hFFFE, 1);
      // R3: both widths, narrow mode ignores reload[15:8]
      run_case("R3", 1'b0, 0, 16'h00FF, 1);
      run_case("R3", 1'b0, 0, 16'hABFA, 2);
      run_case("R3", 1'b0, 1, 16'h12F0, 2);
      run_case("R3", 1'b1, 0, 16'hFF00, 1);
      run_case("R3", 1'b1, 0, 16'hFFFF, 3);
      // R7: postscale sweep, 0 acts as 1
      for (int n = 0; n <= 5; n++) run_case("R7", 1'b1, 1, 16'hFFFD, n);

      // R4 R5: clear after set, clear colliding with overflow (P = 8)
      setup(1'b1, 0, 16'hFFFE, 1);
      en = 1'b1;
      for (int k = 1; k <= 17; k++) begin
         clr = (k == 10 || k == 16);
         @(posedge clk); #1;
         if (k == 7)  check("R4", "flag before overflow", flag, 0);
         if (k == 8)  check("R4", "flag at overflow", flag, 1);
         if (k == 9)  check("R4", "flag held", flag, 1);
         if (k == 10) check("R4", "flag after clear", flag, 0);
         if (k == 15) check("R4", "flag stays clear", flag, 0);
         if (k == 16) check("R5", "set wins over clear", flag, 1);
         if (k == 17) check("R5", "flag still set", flag, 1);
         @(negedge clk);
      end
      clr = 1'b0; en = 1'b0;

      // R8: disable mid-interval, stay idle, restart takes a full interval
      setup(1'b1, 0, 16'hFFFE, 1);
      begin
         logic w0;
         int   moved, first_flag;
         w0 = wave;
         en = 1'b1;
         repeat (5) @(posedge clk);
         @(negedge clk); en = 1'b0;
         moved = 0;
         for (int k = 0; k < 40; k++) begin
            @(posedge clk); #1;
            if (flag || period || wave != w0) moved++;
         end
         check("R8", "activity while disabled", moved, 0);
         @(negedge clk); en = 1'b1;
         first_flag = -1;
         for (int k = 1; k <= 12; k++) begin
            @(posedge clk); #1;
            if (flag && first_flag < 0) first_flag = k;
         end
         check("R8", "first overflow after restart", first_flag, 8);
         @(negedge clk); en = 1'b0;
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule